// File: doc/BRIEF.md
# Dual-Redundant Transient-Filtering Register Pipeline

This block models a hardened register array in which every bit exists twice. Each bit has two data inputs, two outputs and two enable paths, and the two copies are kept apart from input to output. A bit commits a new value only when both of its data inputs carry the same value at the capture edge and both enables are asserted. A short upset in one copy of the logic upstream therefore cannot reach the stored state: that bit keeps its old value in both copies.

The pipeline has two such registers. Between them sits a duplicated combinational stage made of two identical copies of a small user function, `y = x ^ rotl(x, 1)`. Each copy takes its input from a different redundant output of the first register and drives its own input of the second register. A sticky disagreement flag records every capture edge at which the copies disagreed, so that the effect can be observed under test. A synchronous clear input resets the flag.

Top module: `dual_set_filter_reg`

## Requirements
- R1: A synchronous active-high reset drives both copies of both registers and the disagreement flag to zero at the next edge. During reset the data and enable inputs have no effect.
- R2: At an edge where both enables are 1 and `din_a == din_b`, both first-stage outputs take that value. The value is visible after the edge.
- R3: At an edge where both enables are 1, a bit whose two data inputs differ keeps its previous value in both copies. The other bits still load.
- R4: At an edge where exactly one enable is 1, no bit of either register changes.
- R5: At an edge where both enables are 0, no bit of either register changes, and no disagreement is recorded.
- R6: The flag is set at the edge after a disagreement event and then stays set. A disagreement event is either of the following: the enables differ, or at least one enable is 1 while some data bit pair differs.
- R7: `flag_clr` clears the flag at the next edge. When a clear and a new event fall in the same cycle, the event wins and the flag is set.
- R8: The second register loads `f(stage1)` under the same enable rule, where `f(x) = x ^ {x[W-2:0], x[W-1]}`. Each copy of `f` takes its input from its own first-stage copy.
- R9: With fault-free inputs, the two copies of each register output are always equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_a | input | 1 | Enable path of copy A |
| en_b | input | 1 | Enable path of copy B |
| flag_clr | input | 1 | Synchronous clear of the disagreement flag |
| din_a | input | WIDTH | Data input, copy A |
| din_b | input | WIDTH | Data input, copy B |
| stage1_a | output | WIDTH | First register, copy A |
| stage1_b | output | WIDTH | First register, copy B |
| dout_a | output | WIDTH | Second register, copy A |
| dout_b | output | WIDTH | Second register, copy B |
| mismatch_flag | output | 1 | Sticky disagreement flag |

## Verification
The bench builds the block with WIDTH = 8. At that width, single-bit flips can be placed at both the lowest and a middle bit position. The rotate in the user function also wraps the top bit into bit 0, so a wrong wrap would show up on `dout`. A reference model written from the requirements follows the second stage across held and loaded cycles. This exposes any change that lets a one-sided enable or a one-sided data flip through.

// File: rtl/dr_pkg.sv
package dr_pkg;

    localparam int DEF_WIDTH = 8;

    // Per-bit commit decision, evaluated separately for each copy.
    function automatic logic bit_commit(input logic ena, input logic enb,
                                        input logic xa, input logic xb);
        return ena & enb & ~(xa ^ xb);
    endfunction

    // Disagreement seen at a capture edge for a whole word.
    function automatic logic word_event(input logic ena, input logic enb,
                                        input logic any_diff);
        return (ena ^ enb) | ((ena | enb) & any_diff);
    endfunction

endpackage

// File: rtl/dr_func.sv
module dr_func #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] x,
    output logic [WIDTH-1:0] y
);
    // One copy of the user function: x xor x rotated left by one.
    always_comb y = x ^ {x[WIDTH-2:0], x[WIDTH-1]};
endmodule

// File: rtl/dr_reg.sv
module dr_reg
    import dr_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_a,
    input  logic             en_b,
    input  logic [WIDTH-1:0] d_a,
    input  logic [WIDTH-1:0] d_b,
    output logic [WIDTH-1:0] q_a,
    output logic [WIDTH-1:0] q_b,
    output logic             evt
);
    logic [WIDTH-1:0] diff;

    always_comb diff = d_a ^ d_b;
    always_comb evt  = word_event(en_a, en_b, |diff);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        // Master side: next value per copy, each with its own gate.
        logic load_a, load_b;
        logic nxt_a, nxt_b;

        always_comb begin
            load_a = bit_commit(en_a, en_b, d_a[i], d_b[i]);
            nxt_a  = load_a ? d_a[i] : q_a[i];
        end

        always_comb begin
            load_b = bit_commit(en_b, en_a, d_b[i], d_a[i]);
            nxt_b  = load_b ? d_b[i] : q_b[i];
        end

        // Slave side: separate storage per copy.
        always_ff @(posedge clk) begin
            if (rst) q_a[i] <= 1'b0;
            else     q_a[i] <= nxt_a;
        end

        always_ff @(posedge clk) begin
            if (rst) q_b[i] <= 1'b0;
            else     q_b[i] <= nxt_b;
        end
    end
endmodule

// File: rtl/dual_set_filter_reg.sv
module dual_set_filter_reg
    import dr_pkg::*;
#(
    parameter int WIDTH = DEF_WIDTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_a,
    input  logic             en_b,
    input  logic             flag_clr,
    input  logic [WIDTH-1:0] din_a,
    input  logic [WIDTH-1:0] din_b,
    output logic [WIDTH-1:0] stage1_a,
    output logic [WIDTH-1:0] stage1_b,
    output logic [WIDTH-1:0] dout_a,
    output logic [WIDTH-1:0] dout_b,
    output logic             mismatch_flag
);
    logic [WIDTH-1:0] fn_a, fn_b;
    logic             evt1, evt2;

    dr_reg #(.WIDTH(WIDTH)) u_stage1 (
        .clk(clk), .rst(rst), .en_a(en_a), .en_b(en_b),
        .d_a(din_a), .d_b(din_b),
        .q_a(stage1_a), .q_b(stage1_b), .evt(evt1)
    );

    // Two independent copies of the combinational stage.
    dr_func #(.WIDTH(WIDTH)) u_func_a (.x(stage1_a), .y(fn_a));
    dr_func #(.WIDTH(WIDTH)) u_func_b (.x(stage1_b), .y(fn_b));

    dr_reg #(.WIDTH(WIDTH)) u_stage2 (
        .clk(clk), .rst(rst), .en_a(en_a), .en_b(en_b),
        .d_a(fn_a), .d_b(fn_b),
        .q_a(dout_a), .q_b(dout_b), .evt(evt2)
    );

    always_ff @(posedge clk) begin
        if (rst) mismatch_flag <= 1'b0;
        else     mismatch_flag <= (mismatch_flag & ~flag_clr) | evt1 | evt2;
    end
endmodule

// File: rtl/dual_set_filter_reg_chk.sv
module dual_set_filter_reg_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             en_a,
    input logic             en_b,
    input logic             flag_clr,
    input logic [WIDTH-1:0] din_a,
    input logic [WIDTH-1:0] din_b,
    input logic [WIDTH-1:0] stage1_a,
    input logic [WIDTH-1:0] stage1_b,
    input logic [WIDTH-1:0] dout_a,
    input logic [WIDTH-1:0] dout_b,
    input logic             mismatch_flag
);
    logic seen_evt;
    always_comb seen_evt = (en_a != en_b) || ((en_a || en_b) && (din_a != din_b));

    assert_reset_zero_R1: assert property (@(posedge clk)
        rst |=> (stage1_a == '0 && stage1_b == '0 && dout_a == '0 &&
                 dout_b == '0 && !mismatch_flag));

    assert_agree_load_R2: assert property (@(posedge clk) disable iff (rst)
        (en_a && en_b && din_a == din_b) |=> (stage1_a == $past(din_a)));

    assert_one_enable_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (en_a != en_b) |=> ($stable(stage1_a) && $stable(stage1_b) &&
                            $stable(dout_a) && $stable(dout_b)));

    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (!en_a && !en_b) |=> ($stable(stage1_a) && $stable(dout_b)));

    assert_flag_set_R6: assert property (@(posedge clk) disable iff (rst)
        seen_evt |=> mismatch_flag);

    assert_flag_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (flag_clr && !seen_evt) |=> !mismatch_flag);

    assert_copies_equal_R9: assert property (@(posedge clk) disable iff (rst)
        (stage1_a == stage1_b) && (dout_a == dout_b));
endmodule

bind dual_set_filter_reg dual_set_filter_reg_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/dual_set_filter_reg_test.sv
module dual_set_filter_reg_test;
    localparam int PERIOD = 10;
    localparam int W = 8;
    localparam int NV = 11;

    // {en_a, en_b, clr, din_a, din_b, exp_stage1, exp_flag}
    localparam logic [27:0] VEC [NV] = '{
        {3'b110, 8'h3C, 8'h3C, 8'h3C, 1'b0},  // R2
        {3'b110, 8'hA5, 8'hA5, 8'hA5, 1'b0},  // R2
        {3'b110, 8'hFF, 8'hF7, 8'hF7, 1'b1},  // R3 bit3 holds, R6
        {3'b111, 8'h00, 8'h00, 8'h00, 1'b0},  // R7 clear
        {3'b100, 8'h55, 8'h55, 8'h00, 1'b1},  // R4
        {3'b000, 8'h66, 8'h99, 8'h00, 1'b1},  // R5 hold, R6 sticky
        {3'b001, 8'h00, 8'h00, 8'h00, 1'b0},  // R7
        {3'b111, 8'h81, 8'h81, 8'h81, 1'b0},  // R2
        {3'b111, 8'h12, 8'h13, 8'h13, 1'b1},  // R3 bit0 holds, R7 set wins
        {3'b010, 8'h00, 8'h00, 8'h13, 1'b1},  // R4
        {3'b111, 8'hC3, 8'hC3, 8'hC3, 1'b0}   // R2, R7
    };

    logic clk = 1'b0;
    logic rst, en_a, en_b, flag_clr;
    logic [W-1:0] din_a, din_b, stage1_a, stage1_b, dout_a, dout_b;
    logic mismatch_flag;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #(PERIOD/2) clk = ~clk;

    dual_set_filter_reg #(.WIDTH(W)) uut (
        .clk(clk), .rst(rst), .en_a(en_a), .en_b(en_b), .flag_clr(flag_clr),
        .din_a(din_a), .din_b(din_b), .stage1_a(stage1_a), .stage1_b(stage1_b),
        .dout_a(dout_a), .dout_b(dout_b), .mismatch_flag(mismatch_flag)
    );

    function automatic logic [W-1:0] ref_f(input logic [W-1:0] x);
        return x ^ {x[W-2:0], x[W-1]};
    endfunction

    task automatic check(input string req, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        #2;
    endtask

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] s1_model;
        logic [W-1:0] q_model;
        rst = 1'b1; en_a = 1'b0; en_b = 1'b0; flag_clr = 1'b0;
        din_a = '0; din_b = '0;
        repeat (3) cycle();
        check("R1", stage1_a, 8'h00);
        check("R1", stage1_b, 8'h00);
        check("R1", dout_a, 8'h00);
        check("R1", {7'd0, mismatch_flag}, 8'h00);

        @(negedge clk) rst = 1'b0;
        s1_model = '0;
        q_model = '0;
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {en_a, en_b, flag_clr, din_a, din_b} = VEC[i][27:9];
            cycle();
            if (en_a && en_b) q_model = ref_f(s1_model);
            s1_model = VEC[i][8:1];
            check("R2/R3/R4/R5 stage1_a", stage1_a, VEC[i][8:1]);
            check("R9 stage1_b", stage1_b, VEC[i][8:1]);
            check("R8 dout_a", dout_a, q_model);
            check("R9 dout_b", dout_b, q_model);
            check("R6/R7 flag", {7'd0, mismatch_flag}, {7'd0, VEC[i][0]});
        end

        // R8: second stage wraps the top bit into bit 0
        @(negedge clk);
        en_a = 1'b1; en_b = 1'b1; flag_clr = 1'b0; din_a = 8'h80; din_b = 8'h80;
        cycle();
        @(negedge clk);
        cycle();
        check("R8 wrap", dout_a, 8'hC0 ^ 8'h01 ^ 8'h40);

        // R1: reset dominates disagreeing inputs
        @(negedge clk);
        rst = 1'b1; din_a = 8'hFF; din_b = 8'h00; en_a = 1'b1; en_b = 1'b0;
        cycle();
        check("R1 stage1", stage1_a, 8'h00);
        check("R1 dout", dout_b, 8'h00);
        check("R1 flag", {7'd0, mismatch_flag}, 8'h00);

        @(negedge clk);
        rst = 1'b0; en_a = 1'b0; en_b = 1'b0; din_a = '0; din_b = '0;
        cycle();
        check("R5 idle no flag", {7'd0, mismatch_flag}, 8'h00);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule